// File: doc/BRIEF.md
# BCD Calendar Register Bank with Read Freeze and Tamper Capture

This block keeps time of day and a calendar in BCD: hundredths, seconds, minutes, 24-hour hours, day of week, date, month and two-digit year. A 100 Hz enable pulse advances the counters. The bus sees a separate set of visible register copies, not the counters. The visible copies follow the counters one clock later, except in two cases. They hold still while a bus read is walking through the clock registers, so that a multi-byte read is coherent. They also hold after a tamper event, which keeps the time at which the tamper input was seen.

The block sits behind a serial-bus slave that has already decoded the frame. It receives the current address pointer, a one-cycle read strobe for each byte read, a one-cycle STOP pulse and a write strobe with data. It returns the byte at the pointer combinationally. The host sets the time with a write-clock bit. Setting the bit zeroes the hundredths and opens the time registers to writes. Clearing it loads every visible field into the counters. A stop bit halts counting. A tamper enable, a read-only tamper flag and a read-only battery-low flag complete the set.

Top module: `rtc_bcd_cal`

The register window is at 7FF0h-7FFFh, and the offset within the window selects the register:

| Offset | Register | Contents |
|---|---|---|
| 7 | Hundredths | BCD value |
| 8 | Control | D7 write-clock, D0 frequency-test |
| 9 | Seconds | D7 stop, D6:0 BCD value |
| A | Minutes | BCD value |
| B | Hours | BCD value |
| C | Day | D7 battery-low, D4 tamper enable, D3 tamper flag, D2:0 day of week |
| D | Date | BCD value |
| E | Month | BCD value |
| F | Year | BCD value |

## Requirements
- R1: After reset, hundredths, seconds, minutes, hours and year read 00, date and month read 01, day of week reads 1, and the control, stop, tamper-enable and tamper-flag bits read 0.
- R2: Each tick adds one hundredth. Carries ripple in BCD: hundredths wrap at 99, seconds and minutes at 59, hours at 23, and day of week goes from 7 back to 1 on each new day.
- R3: The date wraps to 01 after the last day of the month. That day is 30 for months 04, 06, 09 and 11, and 31 for the other months. February ends on 29 when the year value is divisible by 4 and on 28 otherwise. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R4: When the copies are not frozen, a counter change appears at the visible registers one clock later.
- R5: A read strobe with the pointer at 7FF9h-7FFFh freezes the visible copies. A STOP pulse releases the freeze, and so does a pointer outside 7FF0h-7FFFh. A read strobe at 7FF8h does not freeze the copies.
- R6: Writing 1 to control D7 (write-clock) zeroes the visible hundredths and enables writes to the time registers. Writing 0 to it loads all visible fields into the counters.
- R7: Time-field writes are ignored while write-clock is 0. The stop bit, the frequency-test bit (control D0) and tamper enable stay writable at any time.
- R8: Seconds D7 (stop) set to 1 halts the counters. Writing it to 0 resumes counting.
- R9: With tamper enable (day D4) at 1, a high tamper input sets the tamper flag (day D3) on the next clock and freezes every visible copy. With tamper enable at 0, the tamper input has no effect.
- R10: The tamper flag clears only on a day-register write with D4=0 while the tamper input is low. Writing D3 has no effect on it.
- R11: The battery-low flag (day D7) takes the battery-compare input in the first clock after reset and holds that value until the next reset.
- R12: Unused bits read 0. A pointer outside 7FF7h-7FFFh reads 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset |
| tick100 | input | 1 | 100 Hz count enable, one cycle wide |
| ptr | input | 16 | Current bus address pointer |
| rdStrobe | input | 1 | One-cycle pulse for each byte read at ptr |
| stopPulse | input | 1 | One-cycle pulse on a bus STOP |
| wrEn | input | 1 | Write strobe for the register at ptr |
| wrData | input | 8 | Write data |
| tamperIn | input | 1 | Tamper switch level, high = tripped |
| battLowIn | input | 1 | Battery-compare result, high = low battery |
| rdData | output | 8 | Byte at ptr |

## Verification
The assertions assume that the inputs are synchronous to clk and that every strobe lasts one cycle. They also assume that a write never arrives in the same cycle as a write-clock change it depends on, and that values written while write-clock is 1 are legal BCD. The stimulus meets these assumptions. It drives every input at the falling edge and holds each strobe for exactly one cycle. It issues each register write on its own, and it sets every field to a valid BCD value before the counters load it.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam logic [3:0] OFF_HUND = 4'h7;
  localparam logic [3:0] OFF_CTL  = 4'h8;
  localparam logic [3:0] OFF_SEC  = 4'h9;
  localparam logic [3:0] OFF_MIN  = 4'hA;
  localparam logic [3:0] OFF_HOUR = 4'hB;
  localparam logic [3:0] OFF_DAY  = 4'hC;
  localparam logic [3:0] OFF_DATE = 4'hD;
  localparam logic [3:0] OFF_MON  = 4'hE;
  localparam logic [3:0] OFF_YEAR = 4'hF;

  // every field held as a byte; unused upper bits stay zero
  typedef struct packed {
    logic [7:0] hund;
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] dow;
    logic [7:0] date;
    logic [7:0] month;
    logic [7:0] year;
  } calT;

  typedef struct packed {
    logic advance;
    logic loadCnt;
    logic copyEn;
    logic clearHund;
    logic wrTime;
  } stbT;

  localparam calT CAL_RESET = '{hund: 8'h00, sec: 8'h00, min: 8'h00, hour: 8'h00,
                                dow: 8'h01, date: 8'h01, month: 8'h01, year: 8'h00};

  function automatic logic [7:0] bcdNext(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of month in BCD; y carries the low five bits of the BCD year
  function automatic logic [7:0] monthEnd(input logic [7:0] m, input logic [4:0] y);
    logic leap;
    leap = y[4] ? (y[3:0] == 4'd2 || y[3:0] == 4'd6)
                : (y[3:0] == 4'd0 || y[3:0] == 4'd4 || y[3:0] == 4'd8);
    if (m == 8'h02) return leap ? 8'h29 : 8'h28;
    if (m == 8'h04 || m == 8'h06 || m == 8'h09 || m == 8'h11) return 8'h30;
    return 8'h31;
  endfunction

endpackage

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  stbT        stb,
  input  logic [3:0] wrOff,
  input  logic [7:0] wrByte,
  output calT        visOut,
  output calT        cntOut
);

  calT cnt, vis, nxt;
  logic [7:0] lastDay;

  always_comb begin
    nxt = cnt;
    lastDay = monthEnd(cnt.month, cnt.year[4:0]);
    if (cnt.hund != 8'h99) nxt.hund = bcdNext(cnt.hund);
    else begin
      nxt.hund = 8'h00;
      if (cnt.sec != 8'h59) nxt.sec = bcdNext(cnt.sec);
      else begin
        nxt.sec = 8'h00;
        if (cnt.min != 8'h59) nxt.min = bcdNext(cnt.min);
        else begin
          nxt.min = 8'h00;
          if (cnt.hour != 8'h23) nxt.hour = bcdNext(cnt.hour);
          else begin
            nxt.hour = 8'h00;
            nxt.dow  = (cnt.dow == 8'h07) ? 8'h01 : cnt.dow + 8'h01;
            if (cnt.date != lastDay) nxt.date = bcdNext(cnt.date);
            else begin
              nxt.date = 8'h01;
              if (cnt.month != 8'h12) nxt.month = bcdNext(cnt.month);
              else begin
                nxt.month = 8'h01;
                nxt.year  = (cnt.year == 8'h99) ? 8'h00 : bcdNext(cnt.year);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= CAL_RESET;
    else if (stb.loadCnt) cnt <= vis;
    else if (stb.advance) cnt <= nxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vis <= CAL_RESET;
    else if (stb.wrTime) begin
      case (wrOff)
        OFF_HUND: vis.hund  <= wrByte;
        OFF_SEC:  vis.sec   <= {1'b0, wrByte[6:0]};
        OFF_MIN:  vis.min   <= {1'b0, wrByte[6:0]};
        OFF_HOUR: vis.hour  <= {2'b0, wrByte[5:0]};
        OFF_DAY:  vis.dow   <= {5'b0, wrByte[2:0]};
        OFF_DATE: vis.date  <= {2'b0, wrByte[5:0]};
        OFF_MON:  vis.month <= {3'b0, wrByte[4:0]};
        OFF_YEAR: vis.year  <= wrByte;
        default: ;
      endcase
    end
    else if (stb.clearHund) vis.hund <= 8'h00;
    else if (stb.copyEn) vis <= cnt;
  end

  assign visOut = vis;
  assign cntOut = cnt;

endmodule

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CLK_BASE = 16'h7FF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              rdStrobe,
  input  logic              stopPulse,
  input  logic              wrEn,
  input  logic [2:0]        wrCtl,     // {data D7, data D4, data D0}
  input  logic              tamperIn,
  input  logic              battLowIn,
  output stbT               stb,
  output logic              inWin,
  output logic              wcBit,
  output logic              ftBit,
  output logic              stopBit,
  output logic              tebBit,
  output logic              tfBit,
  output logic              blBit,
  output logic              frozen
);

  localparam int TAG_W = ADDR_W - 4;
  localparam logic [TAG_W-1:0] WIN_TAG = CLK_BASE[ADDR_W-1:4];

  logic [3:0] off;
  logic inClk, ctlWr, secWr, dayWr, timeOff;
  logic blTaken, freeze;

  assign off     = ptr[3:0];
  assign inWin   = (ptr[ADDR_W-1:4] == WIN_TAG);
  assign inClk   = inWin && (off >= OFF_SEC);
  assign ctlWr   = wrEn && inWin && (off == OFF_CTL);
  assign secWr   = wrEn && inWin && (off == OFF_SEC);
  assign dayWr   = wrEn && inWin && (off == OFF_DAY);
  assign timeOff = (off == OFF_HUND) || (off >= OFF_SEC);

  assign stb.advance   = tick && !stopBit;
  assign stb.loadCnt   = ctlWr && wcBit && !wrCtl[2];
  assign stb.clearHund = ctlWr && !wcBit && wrCtl[2];
  assign stb.copyEn    = !wcBit && !freeze && !tfBit;
  assign stb.wrTime    = wrEn && inWin && wcBit && timeOff;
  assign frozen        = freeze || tfBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wcBit <= 1'b0; ftBit <= 1'b0; stopBit <= 1'b0; tebBit <= 1'b0;
      tfBit <= 1'b0; blBit <= 1'b0; blTaken <= 1'b0; freeze <= 1'b0;
    end else begin
      if (ctlWr) begin
        wcBit <= wrCtl[2];
        ftBit <= wrCtl[0];
      end
      if (secWr) stopBit <= wrCtl[2];
      if (dayWr) tebBit <= wrCtl[1];
      if (tebBit && tamperIn) tfBit <= 1'b1;
      else if (dayWr && !wrCtl[1] && !tamperIn) tfBit <= 1'b0;
      if (!blTaken) begin
        blBit   <= battLowIn;
        blTaken <= 1'b1;
      end
      if (rdStrobe && inClk) freeze <= 1'b1;
      else if (stopPulse || !inWin) freeze <= 1'b0;
    end
  end

  // R9: armed tamper input raises the flag on the next edge
  a_r9_tamper_sets: assert property (@(posedge clk) disable iff (!rstN)
    tebBit && tamperIn |=> tfBit);

  // R10: the flag only drops after a disabling day write with the pin low
  a_r10_flag_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tfBit) |-> $past(wrEn && inWin && off == OFF_DAY && !wrCtl[1] && !tamperIn));

  // R11: battery-low sample is held once taken
  a_r11_bl_hold: assert property (@(posedge clk) disable iff (!rstN)
    blTaken && $past(blTaken) |-> $stable(blBit));

endmodule

// File: rtl/rtc_bcd_cal.sv
module rtc_bcd_cal
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CLK_BASE = 16'h7FF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick100,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              rdStrobe,
  input  logic              stopPulse,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              tamperIn,
  input  logic              battLowIn,
  output logic [7:0]        rdData
);

  stbT  stb;
  calT  vis, cnt;
  logic inWin, wcBit, ftBit, stopBit, tebBit, tfBit, blBit, frozen;

  rtc_cal_ctrl #(.ADDR_W(ADDR_W), .CLK_BASE(CLK_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick100), .ptr(ptr), .rdStrobe(rdStrobe),
    .stopPulse(stopPulse), .wrEn(wrEn), .wrCtl({wrData[7], wrData[4], wrData[0]}),
    .tamperIn(tamperIn), .battLowIn(battLowIn), .stb(stb), .inWin(inWin),
    .wcBit(wcBit), .ftBit(ftBit), .stopBit(stopBit), .tebBit(tebBit),
    .tfBit(tfBit), .blBit(blBit), .frozen(frozen)
  );

  rtc_cal_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrOff(ptr[3:0]), .wrByte(wrData),
    .visOut(vis), .cntOut(cnt)
  );

  always_comb begin
    rdData = 8'h00;
    if (inWin) begin
      case (ptr[3:0])
        OFF_HUND: rdData = vis.hund;
        OFF_CTL:  rdData = {wcBit, 6'b0, ftBit};
        OFF_SEC:  rdData = vis.sec | {stopBit, 7'b0};
        OFF_MIN:  rdData = vis.min;
        OFF_HOUR: rdData = vis.hour;
        OFF_DAY:  rdData = vis.dow | {blBit, 2'b0, tebBit, tfBit, 3'b0};
        OFF_DATE: rdData = vis.date;
        OFF_MON:  rdData = vis.month;
        OFF_YEAR: rdData = vis.year;
        default:  rdData = 8'h00;
      endcase
    end
  end

  // R5 / R9: frozen copies move only under a host write
  a_r5_copy_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(frozen) && !$past(wrEn) |-> $stable(vis));

  // R8: counters hold while stopped unless a load happens
  a_r8_stop_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopBit) && !$past(stb.loadCnt) |-> $stable(cnt));

  // R6: raising write-clock leaves the visible hundredths at zero
  a_r6_hund_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wcBit) |-> vis.hund == 8'h00);

endmodule

// File: tb/rtc_bcd_cal_bench.sv
`timescale 1ns/1ps
module rtc_bcd_cal_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick100 = 1'b0;
  logic [15:0] ptr = 16'h0100;
  logic rdStrobe = 1'b0;
  logic stopPulse = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic tamperIn = 1'b0;
  logic battLowIn = 1'b1;
  logic [7:0] rdData;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rtc_bcd_cal u_rtc_bcd_cal (
    .clk(clk), .rstN(rstN), .tick100(tick100), .ptr(ptr), .rdStrobe(rdStrobe),
    .stopPulse(stopPulse), .wrEn(wrEn), .wrData(wrData), .tamperIn(tamperIn),
    .battLowIn(battLowIn), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic expectReg(input string tag, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    ptr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ptr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick100 = 1'b1;
      @(negedge clk); tick100 = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setClock(input logic [7:0] h, s, m, hr, dw, dt, mo, yr);
    wr(16'h7FF8, 8'h80);
    wr(16'h7FF7, h); wr(16'h7FF9, s); wr(16'h7FFA, m); wr(16'h7FFB, hr);
    wr(16'h7FFC, dw); wr(16'h7FFD, dt); wr(16'h7FFE, mo); wr(16'h7FFF, yr);
    wr(16'h7FF8, 8'h00);
    idle(1);
  endtask

  task automatic testReset;
    expectReg("R1 hund", 16'h7FF7, 8'h00);
    expectReg("R1 ctrl", 16'h7FF8, 8'h00);
    expectReg("R1 sec", 16'h7FF9, 8'h00);
    expectReg("R1 hour", 16'h7FFB, 8'h00);
    expectReg("R11 day with bl", 16'h7FFC, 8'h81);
    expectReg("R1 date", 16'h7FFD, 8'h01);
    expectReg("R1 month", 16'h7FFE, 8'h01);
    expectReg("R1 year", 16'h7FFF, 8'h00);
    expectReg("R12 ram addr", 16'h0100, 8'h00);
    expectReg("R12 reserved", 16'h7FF3, 8'h00);
    battLowIn = 1'b0;
    idle(3);
    expectReg("R11 bl held", 16'h7FFC, 8'h81);
  endtask

  task automatic testCarry;
    ticks(1);
    expectReg("R4 hund follows", 16'h7FF7, 8'h01);
    wr(16'h7FF8, 8'h80);
    expectReg("R6 hund zeroed", 16'h7FF7, 8'h00);
    wr(16'h7FF8, 8'h00);
    setClock(8'h99, 8'h09, 8'h00, 8'h05, 8'h03, 8'h10, 8'h03, 8'h23);
    ticks(1);
    expectReg("R2 hund wrap", 16'h7FF7, 8'h00);
    expectReg("R2 sec bcd", 16'h7FF9, 8'h10);
    setClock(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    ticks(1);
    expectReg("R2 sec", 16'h7FF9, 8'h00);
    expectReg("R2 min", 16'h7FFA, 8'h00);
    expectReg("R2 hour", 16'h7FFB, 8'h00);
    expectReg("R2 dow wrap", 16'h7FFC, 8'h81);
    expectReg("R3 date", 16'h7FFD, 8'h01);
    expectReg("R3 month", 16'h7FFE, 8'h01);
    expectReg("R3 year wrap", 16'h7FFF, 8'h00);
  endtask

  task automatic monthCase(input string tag, input logic [7:0] dt, mo, yr,
                           input logic [7:0] expDt, expMo);
    setClock(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, dt, mo, yr);
    ticks(1);
    expectReg({tag, " date"}, 16'h7FFD, expDt);
    expectReg({tag, " month"}, 16'h7FFE, expMo);
  endtask

  task automatic testMonths;
    monthCase("R3 feb common", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
    monthCase("R3 feb leap 28", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
    monthCase("R3 feb leap 29", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
    monthCase("R3 apr 30", 8'h30, 8'h04, 8'h23, 8'h01, 8'h05);
    monthCase("R3 jan 30", 8'h30, 8'h01, 8'h23, 8'h31, 8'h01);
    monthCase("R3 nov 30", 8'h30, 8'h11, 8'h10, 8'h01, 8'h12);
  endtask

  task automatic testFreeze;
    setClock(8'h10, 8'h00, 8'h00, 8'h12, 8'h02, 8'h15, 8'h06, 8'h24);
    expectReg("R6 load hund", 16'h7FF7, 8'h10);
    @(negedge clk); ptr = 16'h7FF9; rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
    ticks(3);
    expectReg("R5 frozen", 16'h7FF7, 8'h10);
    @(negedge clk); stopPulse = 1'b1;
    @(negedge clk); stopPulse = 1'b0;
    idle(1);
    expectReg("R5 stop release", 16'h7FF7, 8'h13);
    @(negedge clk); ptr = 16'h7FFF; rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
    ticks(2);
    expectReg("R5 frozen again", 16'h7FFF, 8'h24);
    expectReg("R5 still frozen", 16'h7FF7, 8'h13);
    @(negedge clk); ptr = 16'h0200;
    idle(2);
    expectReg("R5 ram release", 16'h7FF7, 8'h15);
    @(negedge clk); ptr = 16'h7FF8; rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
    ticks(1);
    expectReg("R5 ctrl no freeze", 16'h7FF7, 8'h16);
  endtask

  task automatic testStopAndIgnore;
    wr(16'h7FF9, 8'h80);
    expectReg("R8 stop reads", 16'h7FF9, 8'h80);
    ticks(3);
    expectReg("R8 halted", 16'h7FF7, 8'h16);
    wr(16'h7FF9, 8'h45);
    expectReg("R7 sec ignored", 16'h7FF9, 8'h00);
    ticks(1);
    expectReg("R8 resumed", 16'h7FF7, 8'h17);
    wr(16'h7FFA, 8'h33);
    expectReg("R7 min ignored", 16'h7FFA, 8'h00);
    wr(16'h7FF8, 8'h01);
    expectReg("R7 ft writable", 16'h7FF8, 8'h01);
    expectReg("R7 hund intact", 16'h7FF7, 8'h17);
    wr(16'h7FF8, 8'h00);
  endtask

  task automatic testTamper;
    @(negedge clk); tamperIn = 1'b1;
    idle(2);
    expectReg("R9 disarmed", 16'h7FFC, 8'h82);
    ticks(1);
    expectReg("R9 disarmed runs", 16'h7FF7, 8'h18);
    @(negedge clk); tamperIn = 1'b0;
    wr(16'h7FFC, 8'h15);
    expectReg("R9 teb set", 16'h7FFC, 8'h92);
    wr(16'h7FFC, 8'h18);
    expectReg("R10 flag not writable", 16'h7FFC, 8'h92);
    @(negedge clk); tamperIn = 1'b1;
    idle(2);
    expectReg("R9 flag set", 16'h7FFC, 8'h9A);
    ticks(2);
    expectReg("R9 capture held", 16'h7FF7, 8'h18);
    wr(16'h7FFC, 8'h00);
    expectReg("R10 pin high keeps flag", 16'h7FFC, 8'h8A);
    @(negedge clk); tamperIn = 1'b0;
    idle(2);
    expectReg("R10 pin low alone", 16'h7FFC, 8'h8A);
    expectReg("R9 still held", 16'h7FF7, 8'h18);
    wr(16'h7FFC, 8'h00);
    idle(1);
    expectReg("R10 flag cleared", 16'h7FFC, 8'h82);
    expectReg("R10 copies resume", 16'h7FF7, 8'h20);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    testReset;
    testCarry;
    testMonths;
    testFreeze;
    testStopAndIgnore;
    testTamper;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule